// File: doc/BRIEF.md
# Real-Time Counter Interrupt Flag Unit

This block collects the interrupt events of a real-time counter running in 32-bit count mode and turns them into one interrupt request line. Overflow, tamper and four compare-match events arrive as single-cycle pulses from neighbouring logic. Eight periodic-interval events are produced internally, from rising edges of the taps of a free-running 10-bit prescaler.

Each event sets its own bit in a 16-bit status word. Software clears a bit by writing a one to it. An interrupt enable mask sits beside the status word. Software sets mask bits through one write address and clears them through another. The request line is high while any status bit and its enable bit are both set.

The register port is simple. Writes take effect on the clock edge where `wr_en` is high. Reads are combinational from `rd_addr`.

Top module: `rtc_irq_flags`

## Requirements
- R1: After reset, the status word reads 0x0000, the enable mask reads 0x0000 and `irq` is 0.
- R2: The status word and the mask use this layout: overflow at bit 15, tamper at bit 14, compare channel n at bit 8+n, periodic flag n at bit n. Bits 13:12 always read 0, and writes to them have no effect.
- R3: If `ovf_pulse`, `tamper_pulse` or `cmp_pulse[n]` is high at a rising clock edge, its status bit reads 1 after that edge and stays 1 until it is cleared.
- R4: The prescaler is a 10-bit counter that wraps. It advances by one on each edge while `presc_en` is high. Periodic flag n is set on the edge after the edge on which prescaler bit n+2 goes from 0 to 1. While the prescaler runs without a break, the flag is therefore set every 2^(n+3) cycles.
- R5: A write to address 0 clears every status bit where `wr_data` holds a 1. Status bits where `wr_data` holds a 0 keep their value.
- R6: If a hardware event and a software clear reach the same status bit on the same edge, the bit reads 1 afterwards.
- R7: A write to address 1 sets the mask bits where `wr_data` is 1. A write to address 2 clears the mask bits where `wr_data` is 1. Zero bits leave the mask unchanged on both addresses. Reads at address 0 return the status word, reads at address 1 or 2 return the mask, and reads at address 3 return 0.
- R8: `irq` equals the OR over all bits of (status AND mask). It follows the status word and the mask in the same cycle, without waiting for a clock edge.
- R9: While `presc_en` is low, the prescaler holds its value and no periodic flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_en | input | 1 | Prescaler count enable |
| ovf_pulse | input | 1 | Counter overflow event pulse |
| tamper_pulse | input | 1 | Tamper event pulse |
| cmp_pulse | input | 4 | Compare-match event pulses, one per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 status, 1 mask set, 2 mask clear |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data |
| irq | output | 1 | Combined interrupt request |

## Verification
The two functions that can fall on the same edge are a hardware set of a status bit and a write-one-to-clear of that bit. The bench provokes this collision in two ways. First, it raises overflow, tamper and compare pulses in the very cycle it writes ones to those bits. Second, it waits for a periodic flag to fire and times a clear write to land on the same edge as that flag's next rise. It then checks that the status bit reads 1 after the edge, while clear bits that had no event are gone. A behavioural model, updated on every edge, must agree with `rd_data` and `irq` throughout.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int FLAG_W     = 16;
  localparam int OVF_BIT    = 15;
  localparam int TAMP_BIT   = 14;
  localparam int CMP_LSB    = 8;
  localparam int NUM_CMP    = 4;
  localparam int NUM_PER    = 8;
  localparam int TAP_OFS    = 2;
  localparam int PRESC_W    = 10;
  localparam int ADDR_W     = 2;
  localparam logic [FLAG_W-1:0] IMPL_BITS = 16'hCFFF;

  typedef enum logic [ADDR_W-1:0] {
    ADR_STATUS = 2'd0,
    ADR_EN_SET = 2'd1,
    ADR_EN_CLR = 2'd2,
    ADR_VOID   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en) cnt_d = cnt_q + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/rtc_period_detect.sv
module rtc_period_detect #(
  parameter int PRESC_W = 10,
  parameter int NUM_PER = 8,
  parameter int TAP_OFS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] cnt,
  output logic [NUM_PER-1:0] rise
);
  localparam int TOP = TAP_OFS + NUM_PER - 1;

  logic [NUM_PER-1:0] tap_now;
  logic [NUM_PER-1:0] tap_q;

  assign tap_now = cnt[TOP:TAP_OFS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap_q <= '0;
    else        tap_q <= tap_now;
  end

  for (genvar i = 0; i < NUM_PER; i++) begin : g_edge
    assign rise[i] = tap_now[i] & ~tap_q[i];
  end

  if (PRESC_W > TOP + 1) begin : g_spare
    logic [PRESC_W-TOP-2:0] unused_hi;
    assign unused_hi = cnt[PRESC_W-1:TOP+1];
  end
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank #(
  parameter int                 W    = 16,
  parameter logic [W-1:0]       IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flg_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      logic upd;
      logic nxt;
      always_comb begin
        upd = set_i[i] | clr_i[i];
        nxt = set_i[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   flg_q[i] <= 1'b0;
        else if (upd) flg_q[i] <= nxt;
      end
    end else begin : g_void
      assign flg_q[i] = 1'b0;
    end
  end

  assign flags_o = flg_q;
endmodule

// File: rtl/rtc_enable_mask.sv
module rtc_enable_mask #(
  parameter int           W    = 16,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] msk_q;
  logic [W-1:0] msk_d;
  logic         msk_ce;

  always_comb begin
    msk_ce = set_we | clr_we;
    msk_d  = msk_q;
    if (set_we) msk_d = msk_q | (bits_i & IMPL);
    if (clr_we) msk_d = msk_q & ~(bits_i & IMPL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      msk_q <= '0;
    else if (msk_ce) msk_q <= msk_d;
  end

  assign mask_o = msk_q;
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                presc_en,
  input  logic                ovf_pulse,
  input  logic                tamper_pulse,
  input  logic [NUM_CMP-1:0]  cmp_pulse,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [FLAG_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [FLAG_W-1:0]   rd_data,
  output logic                irq
);
  logic [PRESC_W-1:0] presc_q;
  logic [NUM_PER-1:0] per_rise;
  logic [FLAG_W-1:0]  hw_set;
  logic [FLAG_W-1:0]  sw_clr;
  logic [FLAG_W-1:0]  flags_q;
  logic [FLAG_W-1:0]  mask_q;
  logic               we_status;
  logic               we_set;
  logic               we_clr;
  reg_addr_e          wa;
  reg_addr_e          ra;

  rtc_prescaler #(.W(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .en(presc_en), .cnt(presc_q)
  );

  rtc_period_detect #(.PRESC_W(PRESC_W), .NUM_PER(NUM_PER), .TAP_OFS(TAP_OFS)) u_per (
    .clk(clk), .rst_n(rst_n), .cnt(presc_q), .rise(per_rise)
  );

  always_comb begin
    wa        = reg_addr_e'(wr_addr);
    we_status = wr_en && (wa == ADR_STATUS);
    we_set    = wr_en && (wa == ADR_EN_SET);
    we_clr    = wr_en && (wa == ADR_EN_CLR);
    sw_clr    = we_status ? (wr_data & IMPL_BITS) : '0;
    hw_set    = '0;
    hw_set[NUM_PER-1:0]              = per_rise;
    hw_set[CMP_LSB+NUM_CMP-1:CMP_LSB] = cmp_pulse;
    hw_set[TAMP_BIT]                 = tamper_pulse;
    hw_set[OVF_BIT]                  = ovf_pulse;
  end

  rtc_flag_bank #(.W(FLAG_W), .IMPL(IMPL_BITS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(hw_set), .clr_i(sw_clr), .flags_o(flags_q)
  );

  rtc_enable_mask #(.W(FLAG_W), .IMPL(IMPL_BITS)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_we(we_set), .clr_we(we_clr),
    .bits_i(wr_data), .mask_o(mask_q)
  );

  always_comb begin
    ra = reg_addr_e'(rd_addr);
    unique case (ra)
      ADR_STATUS:         rd_data = flags_q;
      ADR_EN_SET,
      ADR_EN_CLR:         rd_data = mask_q;
      default:            rd_data = '0;
    endcase
  end

  assign irq = |(flags_q & mask_q);
endmodule

// File: rtl/rtc_irq_flags_chk.sv
module rtc_irq_flags_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        presc_en,
  input logic        ovf_pulse,
  input logic        tamper_pulse,
  input logic [3:0]  cmp_pulse,
  input logic        wr_en,
  input logic [1:0]  wr_addr,
  input logic [15:0] wr_data,
  input logic        irq,
  input logic [15:0] flags_q,
  input logic [15:0] mask_q,
  input logic [9:0]  presc_q
);
  // R2: reserved bits stay zero
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[13:12] == 2'b00) && (mask_q[13:12] == 2'b00));

  // R3 / R6: events always land, even against a clear
  p_ovf_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> flags_q[15]);
  p_tamper_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tamper_pulse |=> flags_q[14]);
  p_cmp_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmp_pulse) |=> ((flags_q[11:8] & $past(cmp_pulse)) == $past(cmp_pulse)));

  // R5: overflow flag falls only through a one written to address 0
  p_ovf_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags_q[15]) |-> $past(wr_en && (wr_addr == 2'd0) && wr_data[15]));

  // R7: mask bit 15 rises only through a set-port write
  p_mask_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mask_q[15]) |-> $past(wr_en && (wr_addr == 2'd1) && wr_data[15]));

  // R8: request only with an enabled active flag
  p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((flags_q & mask_q) != 16'h0000));

  // R9: prescaler holds while disabled
  p_presc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !presc_en |=> $stable(presc_q));

  // R4: prescaler advances while enabled
  p_presc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    presc_en |=> (presc_q == $past(presc_q) + 10'd1));
endmodule

bind rtc_irq_flags rtc_irq_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .presc_en(presc_en), .ovf_pulse(ovf_pulse),
  .tamper_pulse(tamper_pulse), .cmp_pulse(cmp_pulse), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq), .flags_q(flags_q),
  .mask_q(mask_q), .presc_q(presc_q)
);

// File: tb/rtc_irq_flags_test.sv
`timescale 1ns/1ps
module rtc_irq_flags_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        presc_en = 1'b0;
  logic        ovf_pulse = 1'b0;
  logic        tamper_pulse = 1'b0;
  logic [3:0]  cmp_pulse = 4'h0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'h0;
  logic [1:0]  rd_addr = 2'd0;
  logic [15:0] rd_data;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  logic [15:0] m_flags, m_mask;
  int m_presc, m_prev;

  always #2 clk = ~clk;

  rtc_irq_flags uut (
    .clk(clk), .rst_n(rst_n), .presc_en(presc_en), .ovf_pulse(ovf_pulse),
    .tamper_pulse(tamper_pulse), .cmp_pulse(cmp_pulse), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic check(string req, logic [15:0] got, logic [15:0] exp, string what);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // behavioural reference, one step per edge
  always @(posedge clk) begin
    logic [15:0] setv, clrv;
    if (!rst_n) begin
      m_flags = 16'h0; m_mask = 16'h0; m_presc = 0; m_prev = 0;
    end else begin
      setv = 16'h0;
      for (int n = 0; n < 8; n++)
        if (((m_presc >> (n + 2)) & 1) == 1 && ((m_prev >> (n + 2)) & 1) == 0) setv[n] = 1'b1;
      setv[11:8] = cmp_pulse;
      setv[14] = tamper_pulse;
      setv[15] = ovf_pulse;
      clrv = (wr_en && wr_addr == 2'd0) ? (wr_data & 16'hCFFF) : 16'h0;
      m_flags = (m_flags & ~clrv) | setv;
      if (wr_en && wr_addr == 2'd1) m_mask = m_mask | (wr_data & 16'hCFFF);
      if (wr_en && wr_addr == 2'd2) m_mask = m_mask & ~(wr_data & 16'hCFFF);
      m_prev = m_presc;
      if (presc_en) m_presc = (m_presc + 1) % 1024;
    end
    cyc++;
  end

  function automatic logic [15:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return m_flags;
      2'd1, 2'd2: return m_mask;
      default: return 16'h0;
    endcase
  endfunction

  // lockstep compare, 1 ns after each edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check(cur_req, rd_data, m_read(rd_addr), "lockstep rd_data");
      check("R8", {15'h0, irq}, {15'h0, |(m_flags & m_mask)}, "lockstep irq");
    end
  end

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [1:0] a, logic [15:0] exp, string what);
    @(negedge clk);
    rd_addr = a;
    #0.5;
    check(req, rd_data, exp, what);
  endtask

  initial begin
    while (cyc < 150000 && !done) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int c1, c2;
    idle(3);
    rst_n = 1'b1;
    // R1: reset values
    cur_req = "R1";
    rd_chk("R1", 2'd0, 16'h0000, "status after reset");
    rd_chk("R1", 2'd1, 16'h0000, "mask after reset");
    check("R1", {15'h0, irq}, 16'h0, "irq after reset");

    // R7: mask set/clear ports, R2 reserved bits
    cur_req = "R7";
    wr(2'd1, 16'hFFFF);
    rd_chk("R2", 2'd1, 16'hCFFF, "mask reserved bits");
    wr(2'd2, 16'h00F0);
    rd_chk("R7", 2'd2, 16'hCF0F, "mask via clear address");
    wr(2'd1, 16'h0000);
    rd_chk("R7", 2'd1, 16'hCF0F, "mask zero write ignored");
    rd_chk("R7", 2'd3, 16'h0000, "address 3 reads zero");
    wr(2'd2, 16'hFFFF);
    rd_chk("R7", 2'd1, 16'h0000, "mask cleared");

    // R3: external events land after one edge
    cur_req = "R3";
    rd_addr = 2'd0;
    @(negedge clk); ovf_pulse = 1'b1; #0.5;
    check("R3", rd_data & 16'h8000, 16'h0000, "ovf before edge");
    @(negedge clk); ovf_pulse = 1'b0; #0.5;
    check("R3", rd_data & 16'h8000, 16'h8000, "ovf after edge");
    @(negedge clk); tamper_pulse = 1'b1; cmp_pulse = 4'b1010;
    @(negedge clk); tamper_pulse = 1'b0; cmp_pulse = 4'b0000; #0.5;
    check("R3", rd_data & 16'hCF00, 16'hCA00, "tamper and cmp flags");
    @(negedge clk); cmp_pulse = 4'b0101;
    @(negedge clk); cmp_pulse = 4'b0000; #0.5;
    check("R3", rd_data & 16'hCF00, 16'hCF00, "all event flags");
    idle(3); #0.5;
    check("R3", rd_data & 16'hCF00, 16'hCF00, "flags held");

    // R5: mixed W1C patterns
    cur_req = "R5";
    wr(2'd0, 16'h0000);
    rd_chk("R5", 2'd0, 16'hCF00, "zero write no effect");
    wr(2'd0, 16'h8500);
    rd_chk("R5", 2'd0, 16'h4A00, "partial clear");
    wr(2'd0, 16'h3000);
    rd_chk("R2", 2'd0, 16'h4A00, "reserved write no effect");
    wr(2'd0, 16'hFFFF);
    rd_chk("R5", 2'd0, 16'h0000, "full clear");

    // R6: set beats clear on the same edge
    cur_req = "R6";
    @(negedge clk);
    ovf_pulse = 1'b1; tamper_pulse = 1'b1; cmp_pulse = 4'b0001;
    @(negedge clk);
    ovf_pulse = 1'b0; tamper_pulse = 1'b0; cmp_pulse = 4'b0000;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'hC300;
    ovf_pulse = 1'b1; cmp_pulse = 4'b0010;
    @(negedge clk);
    wr_en = 1'b0; ovf_pulse = 1'b0; cmp_pulse = 4'b0000; #0.5;
    check("R6", rd_data & 16'hCF00, 16'h8200, "set wins over clear");

    // R8: interrupt masking
    cur_req = "R8";
    rd_chk("R8", 2'd0, 16'h8200, "status before mask");
    check("R8", {15'h0, irq}, 16'h0, "irq masked");
    wr(2'd1, 16'h0200); #0.5;
    check("R8", {15'h0, irq}, 16'h1, "irq on cmp1 enabled");
    wr(2'd0, 16'h0200); #0.5;
    check("R8", {15'h0, irq}, 16'h0, "irq drops on clear");
    wr(2'd1, 16'h8000); #0.5;
    check("R8", {15'h0, irq}, 16'h1, "irq on ovf enabled");
    wr(2'd2, 16'h8000); #0.5;
    check("R8", {15'h0, irq}, 16'h0, "irq drops on mask");
    wr(2'd0, 16'hFFFF);

    // R4: periodic flag periods
    cur_req = "R4";
    rd_addr = 2'd0;
    @(negedge clk); presc_en = 1'b1;
    for (int n = 0; n < 8; n++) begin
      wr(2'd0, 16'h00FF);
      c1 = 0;
      while (!rd_data[n]) begin @(negedge clk); end
      c1 = cyc;
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h0001 << n;
      @(negedge clk);
      wr_en = 1'b0;
      while (!rd_data[n]) begin @(negedge clk); end
      c2 = cyc;
      check("R4", 16'(c2 - c1), 16'(1 << (n + 3)), $sformatf("period of flag %0d", n));
    end

    // R6: clear write collides with a periodic rise
    cur_req = "R6";
    wr(2'd0, 16'h00FF);
    while (!rd_data[0]) begin @(negedge clk); end
    repeat (7) @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h0001;
    @(negedge clk);
    wr_en = 1'b0; #0.5;
    check("R6", rd_data & 16'h0001, 16'h0001, "periodic set wins over clear");

    // R9: prescaler stopped
    cur_req = "R9";
    @(negedge clk); presc_en = 1'b0;
    idle(2);
    wr(2'd0, 16'hFFFF);
    idle(1100);
    rd_chk("R9", 2'd0, 16'h0000, "no periodic flags while stopped");
    @(negedge clk); presc_en = 1'b1;
    idle(1100);
    rd_chk("R4", 2'd0, 16'h00FF, "periodic flags after restart");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule